// File: doc/BRIEF.md
# Flash Bus Front End with Identification and Sector Write Protection

This block sits between a parallel flash bus and the command and array logic behind it. It reads the active-low chip, output and write strobes and removes short glitches from each. From the filtered strobes it decides whether the bus is idle, in a write, or inhibited. When a qualified write ends, it emits a one-cycle strobe carrying the address and data of that write. If the target sector is protected, it raises a reject pulse instead.

An eight-entry protection register holds one bit per sector and can be set or cleared through a dedicated request port. While the identification enable is high, reads return fixed codes selected by the low address bits instead of array data. A supply-low input forces the block into a lockout state. In lockout, command state is held cleared and every write is discarded.

The controller has four states. **IDLE** waits for a qualified write (IDLE→ARMED when chip and write strobes are low and output strobe is high). **ARMED** holds the write open (ARMED→COMMIT when qualification drops). **COMMIT** lasts one cycle and issues the strobe or the reject (COMMIT→IDLE). **LOCKOUT** is entered from any state while supply-low is seen (any→LOCKOUT) and is left only once supply is good and the strobes no longer qualify a write (LOCKOUT→IDLE).

Top module: `flash_bus_front`

## Requirements
- R1: A write qualified by filtered ce_n=0, we_n=0, oe_n=1 produces exactly one cycle of wr_stb after the qualification ends, with wr_addr and wr_data equal to the bus address and data of that write.
- R2: Holding oe_n low, or holding ce_n high, during a write-enable pulse inhibits the write: no wr_stb and no wr_rej.
- R3: A strobe level lasting fewer than MIN_PULSE clock cycles (default 4) is filtered out and starts no write.
- R4: While supply_low is asserted, cmd_clear is high and writes produce neither wr_stb nor wr_rej. Writes are accepted again after supply_low is released.
- R5: With id_en=1 and addr[6]=0, addr[1]=0, addr[0]=0, a read drives dout=0x01.
- R6: With id_en=1 and addr[6]=0, addr[1]=0, addr[0]=1, a read drives dout=0x6E.
- R7: With id_en=1 and addr[6]=0, addr[1]=1, addr[0]=0, a read drives dout=0x01 if the sector addr[16:14] is protected, else 0x00.
- R8: A write to a protected sector gives a one-cycle wr_rej and no wr_stb. Clearing that sector's bit (prot_req=1, prot_set=0) lets writes through again. Setting uses prot_req=1, prot_set=1, with prot_sector selecting the bit.
- R9: After reset every sector is unprotected and wr_stb, wr_rej and dout_oe are low.
- R10: dout_oe is high only when id_en=1 and ce_n=0 and oe_n=0, one cycle after those inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 17 | Bus address |
| din | input | 8 | Bus write data |
| id_en | input | 1 | Identification mode enable |
| supply_low | input | 1 | Supply below lockout threshold |
| prot_req | input | 1 | Protection change request |
| prot_set | input | 1 | 1 protects, 0 unprotects |
| prot_sector | input | 3 | Sector for protection change |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Read data drive enable |
| wr_stb | output | 1 | Accepted write pulse |
| wr_rej | output | 1 | Rejected write pulse |
| wr_addr | output | 17 | Address of committed write |
| wr_data | output | 8 | Data of committed write |
| cmd_clear | output | 1 | Command state held cleared (lockout) |

## Verification
Two events can fall in the same cycle: a change to the protection register and the commit of a write to that same sector. The bench protects a sector during an open write, before its release, so that the commit sees the new bit. The scoreboard expects a reject for that write, and a strobe once the bit is cleared again. Supply lockout is raised in the middle of an open write. The scoreboard expects no output for the aborted write and counts any unexpected strobe as a failure.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_ARMED   = 2'd1,
        S_COMMIT  = 2'd2,
        S_LOCKOUT = 2'd3
    } bus_state_t;

    localparam logic [7:0] MFR_CODE  = 8'h01;
    localparam logic [7:0] DEV_CODE  = 8'h6E;
    localparam logic [7:0] PROT_YES  = 8'h01;
    localparam logic [7:0] PROT_NO   = 8'h00;
endpackage

// File: rtl/fbf_strobe_filter.sv
module fbf_strobe_filter #(
    parameter int MIN_PULSE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic filt_n
);
    localparam int CW = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;
    localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);

    logic          samp_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= 1'b1;
            filt_n <= 1'b1;
            run_q  <= '0;
        end else begin
            samp_q <= raw_n;
            if (samp_q == filt_n) begin
                run_q <= '0;
            end else if (run_q == LAST) begin
                filt_n <= samp_q;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    AST_FILT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_n) |-> ($past(samp_q) != $past(filt_n))); // R3
endmodule

// File: rtl/fbf_prot_regs.sv
module fbf_prot_regs #(
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chg_req,
    input  logic              chg_set,
    input  logic [SECT_W-1:0] chg_sector,
    input  logic [SECT_W-1:0] wr_sector,
    input  logic [SECT_W-1:0] rd_sector,
    output logic              wr_locked,
    output logic              rd_locked
);
    localparam int NSECT = 1 << SECT_W;

    logic [NSECT-1:0] bits_q;

    for (genvar g = 0; g < NSECT; g++) begin : g_sect
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bits_q[g] <= 1'b0;
            else if (chg_req && chg_sector == SECT_W'(g))
                bits_q[g] <= chg_set;
        end
    end

    assign wr_locked = bits_q[wr_sector];
    assign rd_locked = bits_q[rd_sector];

    AST_PROT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_req && chg_sector == wr_sector) |=> (wr_locked == $past(chg_set) || !$stable(wr_sector))); // R8
endmodule

// File: rtl/fbf_id_decode.sv
module fbf_id_decode
    import fbf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       id_en,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic [2:0] sel,
    input  logic       sect_locked,
    output logic [7:0] dout,
    output logic       dout_oe
);
    logic [7:0] code;

    always_comb begin
        unique case (sel)
            3'b000:  code = MFR_CODE;
            3'b001:  code = DEV_CODE;
            3'b010:  code = sect_locked ? PROT_YES : PROT_NO;
            default: code = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_oe <= 1'b0;
        end else begin
            dout_oe <= id_en && !ce_n && !oe_n;
            dout    <= (id_en && !ce_n && !oe_n) ? code : 8'h00;
        end
    end

    AST_OE_NEEDS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> ($past(id_en) && !$past(ce_n) && !$past(oe_n))); // R10
endmodule

// File: rtl/fbf_bus_fsm.sv
module fbf_bus_fsm
    import fbf_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_f,
    input  logic              oe_f,
    input  logic              we_f,
    input  logic              lock_q,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              sect_locked,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_stb,
    output logic              wr_rej,
    output logic              cmd_clear
);
    bus_state_t state_q, state_d;
    logic       qual;

    assign qual = !ce_f && !we_f && oe_f;

    always_comb begin
        state_d = state_q;
        if (lock_q) begin
            state_d = S_LOCKOUT;
        end else begin
            unique case (state_q)
                S_IDLE:    if (qual)  state_d = S_ARMED;
                S_ARMED:   if (!qual) state_d = S_COMMIT;
                S_COMMIT:  state_d = S_IDLE;
                S_LOCKOUT: if (!qual) state_d = S_IDLE;
                default:   state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && state_d == S_ARMED)
                wr_addr <= addr;
            if (state_d == S_ARMED)
                wr_data <= din;
        end
    end

    always_comb begin
        wr_stb    = 1'b0;
        wr_rej    = 1'b0;
        cmd_clear = 1'b0;
        unique case (state_q)
            S_COMMIT: begin
                wr_stb = !sect_locked;
                wr_rej = sect_locked;
            end
            S_LOCKOUT: cmd_clear = 1'b1;
            default: ;
        endcase
    end

    AST_COMMIT_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || wr_rej) |-> $past(state_q == S_ARMED)); // R1
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R1
    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> !(wr_stb || wr_rej)); // R4
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
    import fbf_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int SECT_W    = 3,
    parameter int MIN_PULSE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              id_en,
    input  logic              supply_low,
    input  logic              prot_req,
    input  logic              prot_set,
    input  logic [SECT_W-1:0] prot_sector,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              wr_stb,
    output logic              wr_rej,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              cmd_clear
);
    localparam int SECT_LO = ADDR_W - SECT_W;

    logic [2:0] raw_strobes, filt_strobes;
    logic       lock_q;
    logic       wr_locked, rd_locked;
    logic [7:0] id_dout;

    assign raw_strobes = {we_n, oe_n, ce_n};

    for (genvar g = 0; g < 3; g++) begin : g_filt
        fbf_strobe_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_n (raw_strobes[g]),
            .filt_n(filt_strobes[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= supply_low;
    end

    fbf_prot_regs #(.SECT_W(SECT_W)) u_prot (
        .clk       (clk),
        .rst_n     (rst_n),
        .chg_req   (prot_req),
        .chg_set   (prot_set),
        .chg_sector(prot_sector),
        .wr_sector (wr_addr[ADDR_W-1:SECT_LO]),
        .rd_sector (addr[ADDR_W-1:SECT_LO]),
        .wr_locked (wr_locked),
        .rd_locked (rd_locked)
    );

    fbf_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_f       (filt_strobes[0]),
        .oe_f       (filt_strobes[1]),
        .we_f       (filt_strobes[2]),
        .lock_q     (lock_q),
        .addr       (addr),
        .din        (din),
        .sect_locked(wr_locked),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_stb     (wr_stb),
        .wr_rej     (wr_rej),
        .cmd_clear  (cmd_clear)
    );

    fbf_id_decode u_id (
        .clk        (clk),
        .rst_n      (rst_n),
        .id_en      (id_en),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .sel        ({addr[6], addr[1], addr[0]}),
        .sect_locked(rd_locked),
        .dout       (id_dout),
        .dout_oe    (dout_oe)
    );

    assign dout = DATA_W'(id_dout);

    AST_STB_REJ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && wr_rej)); // R8
    AST_CLEAR_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> cmd_clear); // R4
endmodule

// File: tb/test_flash_bus_front.sv
module test_flash_bus_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic        id_en = 1'b0, supply_low = 1'b0;
    logic        prot_req = 1'b0, prot_set = 1'b0;
    logic [2:0]  prot_sector = '0;
    logic [7:0]  dout;
    logic        dout_oe, wr_stb, wr_rej, cmd_clear;
    logic [16:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0, fails = 0;
    logic [25:0] expq[$];
    logic [7:0]  prot_m = '0;
    bit          done = 0;

    always #5 clk = ~clk;

    flash_bus_front i_flash_bus_front (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_cycle(input logic [16:0] a, input logic [7:0] d, input bit expect_out,
                               input bit hold_oe_low, input bit hold_ce_high);
        if (expect_out) expq.push_back({prot_m[a[16:14]], a, d});
        addr = a; din = d;
        oe_n = hold_oe_low ? 1'b0 : 1'b1;
        ce_n = hold_ce_high ? 1'b1 : 1'b0;
        step(1);
        we_n = 1'b0;
        step(8);
        we_n = 1'b1;
        step(2);
        ce_n = 1'b1; oe_n = 1'b1;
        step(10);
    endtask

    task automatic set_prot(input logic [2:0] s, input bit v);
        prot_req = 1'b1; prot_set = v; prot_sector = s;
        step(1);
        prot_req = 1'b0;
        prot_m[s] = v;
    endtask

    task automatic id_read(input logic [16:0] a, input logic [7:0] exp, input string tag);
        addr = a; id_en = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        step(2);
        @(negedge clk);
        check(dout_oe == 1'b1, {tag, " dout_oe"}, 32'(dout_oe), 32'd1);
        check(dout == exp, tag, 32'(dout), 32'(exp));
        step(1);
        ce_n = 1'b1; oe_n = 1'b1; id_en = 1'b0;
        step(3);
    endtask

    // Monitor: pops expected commits and compares
    always @(negedge clk) begin
        if (rst_n && (wr_stb || wr_rej)) begin
            if (expq.size() == 0) begin
                check(1'b0, "R1/R2/R3/R4 unexpected commit", {6'd0, wr_rej, wr_addr, wr_data}, 32'd0);
            end else begin
                logic [25:0] e;
                e = expq.pop_front();
                check({wr_rej, wr_addr, wr_data} == e && (wr_stb != wr_rej),
                      "R1/R8 commit item", {6'd0, wr_rej, wr_addr, wr_data}, {6'd0, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        @(negedge clk);
        // R9 reset state
        check(!wr_stb && !wr_rej && !dout_oe, "R9 idle outputs", {wr_stb, wr_rej, dout_oe}, 3'b000);
        for (int s = 0; s < 8; s++)
            id_read({3'(s), 14'h0002}, 8'h00, "R9 sector unprotected after reset");

        // R5, R6 identification codes
        id_read(17'h00000, 8'h01, "R5 manufacturer code");
        id_read(17'h00001, 8'h6E, "R6 device code");

        // R10 no drive without id_en
        ce_n = 1'b0; oe_n = 1'b0; step(3);
        @(negedge clk);
        check(dout_oe == 1'b0, "R10 dout_oe low without id_en", 32'(dout_oe), 32'd0);
        ce_n = 1'b1; step(2);
        id_en = 1'b1; oe_n = 1'b0; step(3);
        @(negedge clk);
        check(dout_oe == 1'b0, "R10 dout_oe low with ce_n high", 32'(dout_oe), 32'd0);
        id_en = 1'b0; oe_n = 1'b1; step(3);

        // R1 accepted writes, several patterns
        write_cycle(17'h1ABCD, 8'h5A, 1, 0, 0);
        write_cycle(17'h00000, 8'hFF, 1, 0, 0);
        write_cycle(17'h0C003, 8'h00, 1, 0, 0);

        // R2 inhibited writes
        write_cycle(17'h01111, 8'h11, 0, 1, 0);
        write_cycle(17'h02222, 8'h22, 0, 0, 1);

        // R3 glitch on we_n with ce_n low: pulse shorter than MIN_PULSE
        addr = 17'h03333; din = 8'h33; ce_n = 1'b0; step(6);
        we_n = 1'b0; step(2); we_n = 1'b1; step(10);
        ce_n = 1'b1; step(10);
        // R3 oe_n high glitch while ce/we low and oe low: no qualification
        oe_n = 1'b0; ce_n = 1'b0; step(6); we_n = 1'b0; step(6);
        oe_n = 1'b1; step(2); oe_n = 1'b0; step(6);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; step(10);
        check(expq.size() == 0, "R3 no commit from short pulses", 32'(expq.size()), 32'd0);

        // R7, R8 protection
        set_prot(3'd5, 1'b1);
        id_read(17'h14002, 8'h01, "R7 sector 5 protected code");
        id_read(17'h18002, 8'h00, "R7 sector 6 unprotected code");
        write_cycle(17'h14010, 8'hA5, 1, 0, 0);   // reject
        write_cycle(17'h18010, 8'hA6, 1, 0, 0);   // accept
        set_prot(3'd5, 1'b0);
        id_read(17'h14002, 8'h00, "R7 sector 5 unprotected again");
        write_cycle(17'h14010, 8'hA7, 1, 0, 0);   // accept again (R8)

        // R8 protection set during an open write of the same sector
        addr = 17'h08020; din = 8'h77; oe_n = 1'b1; ce_n = 1'b0; step(1);
        we_n = 1'b0; step(8);
        prot_req = 1'b1; prot_set = 1'b1; prot_sector = 3'd2; step(1);
        prot_req = 1'b0; prot_m[2] = 1'b1;
        expq.push_back({1'b1, 17'h08020, 8'h77});
        we_n = 1'b1; step(2); ce_n = 1'b1; step(10);
        set_prot(3'd2, 1'b0);
        write_cycle(17'h08020, 8'h78, 1, 0, 0);

        // R4 supply lockout
        supply_low = 1'b1; step(3);
        @(negedge clk);
        check(cmd_clear == 1'b1, "R4 cmd_clear during lockout", 32'(cmd_clear), 32'd1);
        write_cycle(17'h04444, 8'h44, 0, 0, 0);
        supply_low = 1'b0; step(3);
        @(negedge clk);
        check(cmd_clear == 1'b0, "R4 cmd_clear released", 32'(cmd_clear), 32'd0);
        write_cycle(17'h04445, 8'h45, 1, 0, 0);
        // R4 lockout raised during an open write aborts it
        addr = 17'h05555; din = 8'h55; ce_n = 1'b0; step(1);
        we_n = 1'b0; step(8);
        supply_low = 1'b1; step(3);
        we_n = 1'b1; step(2); ce_n = 1'b1; step(4);
        supply_low = 1'b0; step(6);
        write_cycle(17'h05556, 8'h56, 1, 0, 0);

        step(10);
        check(expq.size() == 0, "R1 all expected commits seen", 32'(expq.size()), 32'd0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule